// File: doc/BRIEF.md
# Toggle-Position Horizontal Blanking Generator

This block produces the per-line horizontal blanking waveform for an image-sensor timing path. A pixel counter restarts on every line-start strobe. A bank of up to six programmable toggle points is compared against that counter. Each enabled point that the counter has reached or passed inverts the blanking level once. Two points give an ordinary blanking window. Further points cut extra pulse groups into that window.

The toggle registers are copied into shadow storage only on the line-start strobe. Software may therefore rewrite them at any time without disturbing the line in progress.

A source-select bit can bypass the internal generator and take blanking from an external pin instead. That pin has a programmable active level, and it is normalised to active-high before use. While blanking is asserted, the horizontal clock output H1 is held at a programmable level. At all other times H1 passes the incoming H1 clock through unchanged.

Top module: `blank_toggle_gen`

## Requirements
- R1: After reset, `blank_o` is low and `h1_o` equals `h1_i`.
- R2: The pixel counter restarts at 0 on `line_start_i` and advances by one per clock. It stops at 2^CNT_W-1 and does not wrap, so no toggle point is crossed a second time in a long line.
- R3: In internal mode (`ext_sel_i`=0), `blank_o` is low in the cycle after `line_start_i`. In the n-th cycle after that (n≥1), `blank_o` equals the parity of the number of enabled toggle points whose value is ≤ min(n-1, 2^CNT_W-1).
- R4: With only the first two toggle points enabled, at values a<b, `blank_o` is high exactly while n-1 lies in [a, b).
- R5: Enabling the third to sixth toggle points adds further pulse groups inside the window. Each enabled point inverts the level once.
- R6: A toggle point holding the all-ones value is disabled and has no effect on `blank_o`, wherever it sits in the list.
- R7: Toggle values are captured only on the `line_start_i` clock. A change to `tog_pos_i` in the middle of a line does not alter that line's waveform.
- R8: With `ext_sel_i`=1, `blank_o` follows `ext_blank_i` one clock later, normalised to active-high. The polarity encoding is: `ext_pol_i`=0 means the pin is active low, and `ext_pol_i`=1 means active high. `line_start_i` does not clear the output in this mode.
- R9: While `blank_o` is high, `h1_o` equals `mask_pol_i` (0 holds H1 low, 1 holds H1 high). While `blank_o` is low, `h1_o` equals `h1_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start_i | input | 1 | One-cycle strobe at the start of each line |
| tog_pos_i | input | N_TOG*CNT_W | Toggle points; point k occupies bits [k*CNT_W +: CNT_W]; all-ones disables |
| ext_sel_i | input | 1 | 1 selects the external blanking source |
| ext_pol_i | input | 1 | Active level of the external pin (0 low, 1 high) |
| mask_pol_i | input | 1 | Level H1 is held at during blanking |
| ext_blank_i | input | 1 | External blanking pin |
| h1_i | input | 1 | Incoming H1 clock |
| blank_o | output | 1 | Active-high blanking |
| h1_o | output | 1 | H1 after blanking mask |

## Verification
Several corner cases are targeted directly:
- A counter that wraps instead of stopping would drop the blanking level back low past count 255. A long line with an odd number of enabled points exposes this.
- A disabled point placed between enabled ones would add a spurious edge if it were not ignored.
- A write to the toggle inputs in the middle of a line would move edges within that same line if the registers were not shadowed.
- In external mode, a swapped polarity sense would invert the output. A line strobe wrongly clearing the output would show as a dropped cycle.

Random sorted toggle sets, together with random H1 and mask levels, cover the remaining parity and masking combinations.

// File: rtl/blank_pkg.sv
`timescale 1ns/1ps
package blank_pkg;

    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } blank_src_e;

    typedef struct packed {
        blank_src_e src;
        logic       ext_act_high;
        logic       h1_hold_lvl;
    } blank_cfg_t;

    // Bring an external blanking pin to active-high form.
    function automatic logic normalise_ext(input logic raw, input logic act_high);
        return act_high ? raw : ~raw;
    endfunction

endpackage

// File: rtl/blank_pix_counter.sv
`timescale 1ns/1ps
module blank_pix_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_start_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_q;

    // Saturating counter; reset parks it at the top so nothing fires before the first line.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_TOP;
        end else if (line_start_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    a_r2_restart: assert property (@(posedge clk) disable iff (rst)
        line_start_i |=> (cnt_o == '0));

    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        (!line_start_i && cnt_o != CNT_TOP) |=> (cnt_o == $past(cnt_o) + 1'b1));

    a_r2_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!line_start_i && cnt_o == CNT_TOP) |=> (cnt_o == CNT_TOP));

endmodule

// File: rtl/blank_toggle_bank.sv
`timescale 1ns/1ps
module blank_toggle_bank #(
    parameter int CNT_W = 12,
    parameter int N_TOG = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   line_start_i,
    input  logic [N_TOG*CNT_W-1:0] tog_pos_i,
    input  logic [CNT_W-1:0]       cnt_i,
    output logic                   blank_int_o
);
    localparam logic [CNT_W-1:0] TOG_OFF = '1;

    logic [N_TOG-1:0][CNT_W-1:0] shadow_q;
    logic [N_TOG-1:0]            passed;

    // Shadow copy: loaded only on the line strobe.
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '1;
        end else if (line_start_i) begin
            shadow_q <= tog_pos_i;
        end
    end

    // One comparator per toggle point; the parity of points passed gives the level.
    for (genvar g = 0; g < N_TOG; g++) begin : g_cmp
        assign passed[g] = (shadow_q[g] != TOG_OFF) && (cnt_i >= shadow_q[g]);
    end

    assign blank_int_o = ^passed;

    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        !line_start_i |=> $stable(shadow_q));

    a_r7_shadow_load: assert property (@(posedge clk) disable iff (rst)
        line_start_i |=> (shadow_q == $past(tog_pos_i)));

endmodule

// File: rtl/blank_src_select.sv
`timescale 1ns/1ps
module blank_src_select
    import blank_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       line_start_i,
    input  logic       blank_int_i,
    input  blank_cfg_t cfg_i,
    input  logic       ext_blank_i,
    input  logic       h1_i,
    output logic       blank_o,
    output logic       h1_o
);
    logic ext_norm;
    logic blank_q;

    assign ext_norm = normalise_ext(ext_blank_i, cfg_i.ext_act_high);

    always_ff @(posedge clk) begin
        if (rst) begin
            blank_q <= 1'b0;
        end else if (cfg_i.src == SRC_EXTERNAL) begin
            blank_q <= ext_norm;
        end else if (line_start_i) begin
            blank_q <= 1'b0;
        end else begin
            blank_q <= blank_int_i;
        end
    end

    assign blank_o = blank_q;
    assign h1_o    = blank_q ? cfg_i.h1_hold_lvl : h1_i;

    a_r8_ext_follow: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.src == SRC_EXTERNAL) |=> (blank_o == $past(ext_blank_i == cfg_i.ext_act_high)));

    a_r3_line_low: assert property (@(posedge clk) disable iff (rst)
        (line_start_i && cfg_i.src == SRC_INTERNAL) |=> !blank_o);

    a_r9_h1_held: assert property (@(posedge clk) disable iff (rst)
        blank_o |-> (h1_o == cfg_i.h1_hold_lvl));

endmodule

// File: rtl/blank_toggle_gen.sv
`timescale 1ns/1ps
module blank_toggle_gen
    import blank_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int N_TOG = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   line_start_i,
    input  logic [N_TOG*CNT_W-1:0] tog_pos_i,
    input  logic                   ext_sel_i,
    input  logic                   ext_pol_i,
    input  logic                   mask_pol_i,
    input  logic                   ext_blank_i,
    input  logic                   h1_i,
    output logic                   blank_o,
    output logic                   h1_o
);
    logic [CNT_W-1:0] pix_cnt;
    logic             blank_int;
    blank_cfg_t       cfg;

    assign cfg.src          = ext_sel_i ? SRC_EXTERNAL : SRC_INTERNAL;
    assign cfg.ext_act_high = ext_pol_i;
    assign cfg.h1_hold_lvl  = mask_pol_i;

    blank_pix_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk          (clk),
        .rst          (rst),
        .line_start_i (line_start_i),
        .cnt_o        (pix_cnt)
    );

    blank_toggle_bank #(.CNT_W(CNT_W), .N_TOG(N_TOG)) i_bank (
        .clk          (clk),
        .rst          (rst),
        .line_start_i (line_start_i),
        .tog_pos_i    (tog_pos_i),
        .cnt_i        (pix_cnt),
        .blank_int_o  (blank_int)
    );

    blank_src_select i_sel (
        .clk          (clk),
        .rst          (rst),
        .line_start_i (line_start_i),
        .blank_int_i  (blank_int),
        .cfg_i        (cfg),
        .ext_blank_i  (ext_blank_i),
        .h1_i         (h1_i),
        .blank_o      (blank_o),
        .h1_o         (h1_o)
    );

    a_r1_idle_low: assert property (@(posedge clk) rst |=> !blank_o);

endmodule

// File: tb/test_blank_toggle_gen.sv
`timescale 1ns/1ps
module test_blank_toggle_gen;
    localparam int CW   = 8;
    localparam int NT   = 6;
    localparam int TOPV = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_start_i = 1'b0;
    logic [NT*CW-1:0] tog_pos_i = '1;
    logic ext_sel_i = 1'b0, ext_pol_i = 1'b0, mask_pol_i = 1'b0;
    logic ext_blank_i = 1'b0, h1_i = 1'b0;
    logic blank_o, h1_o;

    int tests = 0;
    int fails = 0;
    int pos[NT];
    int msh[NT];

    always #10 clk = ~clk;

    blank_toggle_gen #(.CNT_W(CW), .N_TOG(NT)) i_blank_toggle_gen (
        .clk(clk), .rst(rst), .line_start_i(line_start_i), .tog_pos_i(tog_pos_i),
        .ext_sel_i(ext_sel_i), .ext_pol_i(ext_pol_i), .mask_pol_i(mask_pol_i),
        .ext_blank_i(ext_blank_i), .h1_i(h1_i), .blank_o(blank_o), .h1_o(h1_o)
    );

    task automatic chk(input logic got, input logic expv, input string req);
        tests++;
        if (got !== expv) begin
            fails++;
            $display("FAIL %s got=%0b exp=%0b at %0t", req, got, expv, $time);
        end
    endtask

    function automatic logic model_blank(input int c);
        int n = 0;
        for (int i = 0; i < NT; i++)
            if (msh[i] != TOPV && msh[i] <= c) n++;
        return n[0];
    endfunction

    task automatic drive_pos();
        for (int i = 0; i < NT; i++) tog_pos_i[i*CW +: CW] = pos[i][CW-1:0];
    endtask

    task automatic check_h1(input string req);
        chk(h1_o, blank_o ? mask_pol_i : h1_i, req);
        h1_i = 1'($urandom);
    endtask

    // Runs one internal line; optionally rewrites the toggle inputs at cycle wr_at (R7).
    task automatic run_line(input int len, input int wr_at, input string req);
        drive_pos();
        for (int i = 0; i < NT; i++) msh[i] = pos[i];
        line_start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        line_start_i = 1'b0;
        chk(blank_o, 1'b0, "R3 low after line start");
        for (int n = 1; n <= len; n++) begin
            @(posedge clk);
            @(negedge clk);
            chk(blank_o, model_blank((n - 1 > TOPV) ? TOPV : n - 1), req);
            check_h1("R9 H1 mask");
            if (n == wr_at) tog_pos_i = NT*CW'($urandom);
        end
    endtask

    task automatic rand_sorted();
        int k = 2 + int'($urandom_range(NT - 2));
        for (int i = 0; i < NT; i++) pos[i] = (i < k) ? int'($urandom_range(TOPV - 1)) : TOPV;
        for (int i = 1; i < k; i++)
            for (int j = i; j > 0 && pos[j-1] > pos[j]; j--) begin
                int t = pos[j]; pos[j] = pos[j-1]; pos[j-1] = t;
            end
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic prev;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        h1_i = 1'b1;
        @(negedge clk);
        chk(blank_o, 1'b0, "R1 reset blank");
        chk(h1_o, h1_i, "R1 reset h1");

        pos = '{10, 40, TOPV, TOPV, TOPV, TOPV};
        mask_pol_i = 1'b1;
        run_line(60, 0, "R4 standard window");

        pos = '{5, 8, 12, 15, 20, 30};
        mask_pol_i = 1'b0;
        run_line(45, 0, "R5 six toggles");

        pos = '{10, TOPV, 20, 30, TOPV, 40};
        run_line(50, 0, "R6 disabled point ignored");

        pos = '{6, 25, 30, 50, TOPV, TOPV};
        run_line(70, 12, "R7 mid-line write");
        run_line(70, 40, "R7 mid-line write");

        pos = '{3, 10, 200, TOPV, TOPV, TOPV};
        run_line(300, 0, "R2 saturate no wrap");

        for (int p = 0; p < 2; p++) begin
            ext_sel_i = 1'b1;
            ext_pol_i = p[0];
            ext_blank_i = 1'($urandom);
            prev = (ext_blank_i == ext_pol_i);
            for (int n = 0; n < 40; n++) begin
                @(posedge clk);
                @(negedge clk);
                line_start_i = 1'b0;
                chk(blank_o, prev, "R8 external source");
                check_h1("R9 H1 mask ext");
                ext_blank_i = 1'($urandom);
                prev = (ext_blank_i == ext_pol_i);
                if (n % 9 == 4) line_start_i = 1'b1;
            end
        end
        ext_sel_i = 1'b0;

        for (int r = 0; r < 40; r++) begin
            rand_sorted();
            mask_pol_i = 1'($urandom);
            run_line(50 + int'($urandom_range(230)), int'($urandom_range(60)), "R3 random toggles");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule